// File: doc/BRIEF.md
# Three-Table Majority Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps three separate tables of 2-bit saturating counters. Each table has a different number of entries. A branch address selects one counter in each table, using the address modulo that table's entry count. Because the sizes differ, two branches that collide in one table seldom collide in the others. The three per-table guesses are then combined by a two-out-of-three vote.

The front end presents a branch address on the lookup port. One clock later, the block returns the combined direction, the three individual votes and a valid flag. When a branch resolves, its address and real outcome arrive on the update port. Every table then trains the counter that address selects, whatever that table had predicted.

Top module: `tri_vote_predictor`

## Requirements
- R1: The tables hold SIZE_A (default 1024), SIZE_B (default 512) and SIZE_C (default 768) counters. For a 32-bit byte address `pc`, each table uses entry `pc mod size`, with no shift or alignment. The 768-entry table therefore aliases addresses 768 apart, while the 1024-entry table does not.
- R2: Reset sets every counter in every table to 00 and clears `pred_valid`, `pred_taken` and `pred_votes`. After reset, a lookup of any address returns votes 000 and not-taken.
- R3: A counter votes taken when its upper bit is 1 (states 11 and 10) and not taken for 01 and 00. `pred_votes` bit 0 is the SIZE_A table, bit 1 the SIZE_B table and bit 2 the SIZE_C table.
- R4: `pred_taken` is 1 exactly when at least two bits of `pred_votes` are 1.
- R5: An accepted update with `up_taken`=1 raises each selected counter by one, holding at 11.
- R6: An accepted update with `up_taken`=0 lowers each selected counter by one, holding at 00.
- R7: Every accepted update trains all three tables, regardless of what each table predicted.
- R8: A lookup presented at one rising edge gives its result after that edge, with `pred_valid`=1. After an edge with no lookup, `pred_valid` is 0 and `pred_votes` and `pred_taken` keep their last values.
- R9: When a lookup and an update select the same counter at the same edge, the lookup returns the state from before that update. The update still takes effect for later lookups.
- R10: While `up_valid` is 0, `up_pc` and `up_taken` change no counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_pc | input | 32 | Branch byte address to predict |
| up_valid | input | 1 | Resolved-branch training request |
| up_pc | input | 32 | Byte address of the resolved branch |
| up_taken | input | 1 | Real outcome: 1 taken, 0 not taken |
| pred_valid | output | 1 | Result below belongs to the previous edge's lookup |
| pred_taken | output | 1 | Majority direction |
| pred_votes | output | 3 | Per-table votes (bit 0 A, bit 1 B, bit 2 C) |

## Verification
Lookup results are registered once, so they become visible in the half-cycle after the edge that captured the address. Training is written at the same edge, so it affects only lookups taken at a later edge. The bench drives both ports on the falling edge. It predicts the result from a software copy of the three tables, reading the copy before applying that cycle's update. It compares the outputs at the next falling edge, which is one full register stage later.

// File: rtl/bp_pkg.sv
package bp_pkg;

   typedef logic [1:0] ctr_t;

   localparam ctr_t CTR_TOP = 2'b11;
   localparam ctr_t CTR_BOT = 2'b00;

   // Saturating step of a 2-bit direction counter
   function automatic ctr_t ctr_step(ctr_t cur, logic up);
      ctr_t nxt;
      if (up) nxt = (cur == CTR_TOP) ? cur : cur + 2'd1;
      else    nxt = (cur == CTR_BOT) ? cur : cur - 2'd1;
      return nxt;
   endfunction

   // Upper bit of the counter gives the direction
   function automatic logic ctr_vote(ctr_t cur);
      return cur[1];
   endfunction

endpackage

// File: rtl/bp_mod_index.sv
module bp_mod_index #(
   parameter int unsigned PC_W    = 32,
   parameter int unsigned ENTRIES = 768,
   localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic [PC_W-1:0]  pc,
   output logic [IDX_W-1:0] idx
);

   localparam bit IS_POW2 = ((ENTRIES & (ENTRIES - 1)) == 0);

   initial begin
      assert (ENTRIES >= 2) else $error("bp_mod_index: ENTRIES must be at least 2");
      assert (PC_W >= IDX_W) else $error("bp_mod_index: PC_W narrower than index");
   end

   generate
      if (IS_POW2) begin : g_slice
         assign idx = pc[IDX_W-1:0];
      end else begin : g_modulo
         logic [PC_W-1:0] rem;
         assign rem = pc % PC_W'(ENTRIES);
         assign idx = rem[IDX_W-1:0];
      end
   endgenerate

endmodule

// File: rtl/bp_ctr_table.sv
module bp_ctr_table
   import bp_pkg::*;
#(
   parameter int unsigned PC_W    = 32,
   parameter int unsigned ENTRIES = 1024,
   localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            lk_valid,
   input  logic [PC_W-1:0] lk_pc,
   input  logic            up_valid,
   input  logic [PC_W-1:0] up_pc,
   input  logic            up_taken,
   output logic            vote
);

   ctr_t             mem [ENTRIES];
   ctr_t             rd_state;
   logic [IDX_W-1:0] lk_idx;
   logic [IDX_W-1:0] up_idx;

   bp_mod_index #(.PC_W(PC_W), .ENTRIES(ENTRIES)) u_lk_idx (
      .pc  (lk_pc),
      .idx (lk_idx)
   );

   bp_mod_index #(.PC_W(PC_W), .ENTRIES(ENTRIES)) u_up_idx (
      .pc  (up_pc),
      .idx (up_idx)
   );

   // Counter storage: training write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) mem[i] <= CTR_BOT;
      end else if (up_valid) begin
         mem[up_idx] <= ctr_step(mem[up_idx], up_taken);
      end
   end

   // Lookup read register: old contents on same-edge write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        rd_state <= CTR_BOT;
      else if (lk_valid) rd_state <= mem[lk_idx];
   end

   assign vote = ctr_vote(rd_state);

   // Checker state capturing the last write
   logic             ck_v;
   logic [IDX_W-1:0] ck_idx;
   ctr_t             ck_old;
   logic             ck_dir;
   ctr_t             ck_want;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ck_v   <= 1'b0;
         ck_idx <= '0;
         ck_old <= CTR_BOT;
         ck_dir <= 1'b0;
      end else begin
         ck_v   <= up_valid;
         ck_idx <= up_idx;
         ck_old <= mem[up_idx];
         ck_dir <= up_taken;
      end
   end

   always_comb begin
      unique case ({ck_dir, ck_old})
         3'b100:  ck_want = 2'b01;
         3'b101:  ck_want = 2'b10;
         3'b110:  ck_want = 2'b11;
         3'b111:  ck_want = 2'b11;
         3'b000:  ck_want = 2'b00;
         3'b001:  ck_want = 2'b00;
         3'b010:  ck_want = 2'b01;
         default: ck_want = 2'b10;
      endcase
   end

   // R5 R6
   sat_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ck_v |-> (mem[ck_idx] == ck_want));

   // R1
   idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      up_valid |-> (32'(up_idx) < ENTRIES));

   // R8
   vote_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> $stable(vote));

endmodule

// File: rtl/bp_majority.sv
module bp_majority #(
   parameter int unsigned N = 3,
   localparam int unsigned CNT_W = $clog2(N + 1)
) (
   input  logic [N-1:0] votes,
   output logic         taken
);

   initial begin
      assert (N % 2 == 1) else $error("bp_majority: N must be odd");
   end

   logic [CNT_W-1:0] ones;

   always_comb begin
      ones = '0;
      for (int i = 0; i < N; i++) ones = ones + CNT_W'(votes[i]);
   end

   assign taken = (ones > CNT_W'(N / 2));

endmodule

// File: rtl/tri_vote_predictor.sv
module tri_vote_predictor #(
   parameter int unsigned PC_W   = 32,
   parameter int unsigned SIZE_A = 1024,
   parameter int unsigned SIZE_B = 512,
   parameter int unsigned SIZE_C = 768
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            lk_valid,
   input  logic [PC_W-1:0] lk_pc,
   input  logic            up_valid,
   input  logic [PC_W-1:0] up_pc,
   input  logic            up_taken,
   output logic            pred_valid,
   output logic            pred_taken,
   output logic [2:0]      pred_votes
);

   localparam int unsigned NTBL = 3;

   function automatic int unsigned tbl_size(int k);
      case (k)
         0:       return SIZE_A;
         1:       return SIZE_B;
         default: return SIZE_C;
      endcase
   endfunction

   initial begin
      assert (SIZE_A != SIZE_B && SIZE_B != SIZE_C && SIZE_A != SIZE_C)
         else $error("tri_vote_predictor: table sizes should differ");
   end

   logic [NTBL-1:0] votes;

   generate
      for (genvar g = 0; g < NTBL; g++) begin : g_tbl
         bp_ctr_table #(.PC_W(PC_W), .ENTRIES(tbl_size(g))) u_tbl (
            .clk      (clk),
            .rst_n    (rst_n),
            .lk_valid (lk_valid),
            .lk_pc    (lk_pc),
            .up_valid (up_valid),
            .up_pc    (up_pc),
            .up_taken (up_taken),
            .vote     (votes[g])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pred_valid <= 1'b0;
      else        pred_valid <= lk_valid;
   end

   bp_majority #(.N(NTBL)) u_vote (
      .votes (votes),
      .taken (pred_taken)
   );

   assign pred_votes = votes;

   // R8
   valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> pred_valid);

   // R8
   valid_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> !pred_valid);

   // R4
   majority_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pred_taken == ($countones(pred_votes) >= 2));

   // R8
   taken_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> $stable(pred_taken));

endmodule

// File: tb/sim_tri_vote_predictor.sv
module sim_tri_vote_predictor;

   localparam int CLK_PERIOD = 10;
   localparam int SA = 1024;
   localparam int SB = 512;
   localparam int SC = 768;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lk_valid = 1'b0;
   logic [31:0] lk_pc = '0;
   logic        up_valid = 1'b0;
   logic [31:0] up_pc = '0;
   logic        up_taken = 1'b0;
   logic        pred_valid;
   logic        pred_taken;
   logic [2:0]  pred_votes;

   always #(CLK_PERIOD / 2) clk = ~clk;

   tri_vote_predictor #(.PC_W(32), .SIZE_A(SA), .SIZE_B(SB), .SIZE_C(SC)) u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .lk_valid   (lk_valid),
      .lk_pc      (lk_pc),
      .up_valid   (up_valid),
      .up_pc      (up_pc),
      .up_taken   (up_taken),
      .pred_valid (pred_valid),
      .pred_taken (pred_taken),
      .pred_votes (pred_votes)
   );

   int   errors = 0;
   int   checks = 0;
   bit   finished = 1'b0;
   int   ma [SA];
   int   mb [SB];
   int   mc [SC];
   logic [2:0] exp_votes = 3'b000;
   logic       exp_taken = 1'b0;
   string      phase = "R2";

   function automatic int sat(int s, bit up);
      if (up) return (s == 3) ? 3 : s + 1;
      return (s == 0) ? 0 : s - 1;
   endfunction

   function automatic logic [2:0] model_votes(logic [31:0] pc);
      logic [2:0] v;
      v[0] = (ma[pc % 32'(SA)] >= 2);
      v[1] = (mb[pc % 32'(SB)] >= 2);
      v[2] = (mc[pc % 32'(SC)] >= 2);
      return v;
   endfunction

   function automatic logic maj(logic [2:0] v);
      return (int'(v[0]) + int'(v[1]) + int'(v[2])) >= 2;
   endfunction

   task automatic check(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // One cycle: drive on falling edge, compare at the next falling edge
   task automatic step(bit lv, logic [31:0] lp, bit uv, logic [31:0] upc, bit ud);
      lk_valid = lv; lk_pc = lp; up_valid = uv; up_pc = upc; up_taken = ud;
      if (lv) begin
         exp_votes = model_votes(lp);
         exp_taken = maj(exp_votes);
      end
      if (uv) begin
         ma[upc % 32'(SA)] = sat(ma[upc % 32'(SA)], ud);
         mb[upc % 32'(SB)] = sat(mb[upc % 32'(SB)], ud);
         mc[upc % 32'(SC)] = sat(mc[upc % 32'(SC)], ud);
      end
      @(negedge clk);
      check({"R8 valid ", phase}, int'(pred_valid), int'(lv));
      check({"R3 votes ", phase}, int'(pred_votes), int'(exp_votes));
      check({"R4 taken ", phase}, int'(pred_taken), int'(exp_taken));
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd12345));
      for (int i = 0; i < SA; i++) ma[i] = 0;
      for (int i = 0; i < SB; i++) mb[i] = 0;
      for (int i = 0; i < SC; i++) mc[i] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R2: outputs cleared by reset
      check("R2 valid after reset", int'(pred_valid), 0);
      check("R2 votes after reset", int'(pred_votes), 0);
      check("R2 taken after reset", int'(pred_taken), 0);
      phase = "R2";
      step(1, 32'h0000_1234, 0, 0, 0);
      step(1, 32'hFFFF_FFFC, 0, 0, 0);

      // R8: idle cycle holds the result and drops valid
      phase = "R8";
      step(0, 0, 0, 0, 0);

      // R5: train taken repeatedly, saturating at 11
      phase = "R5";
      for (int k = 0; k < 5; k++) step(1, 32'd40, 1, 32'd40, 1);
      step(1, 32'd40, 0, 0, 0);

      // R6: train not taken repeatedly, saturating at 00
      phase = "R6";
      for (int k = 0; k < 5; k++) step(1, 32'd40, 1, 32'd40, 0);
      step(1, 32'd40, 0, 0, 0);

      // R1: only the 768 table aliases 5 with 773
      phase = "R1";
      step(0, 0, 1, 32'd5, 1);
      step(0, 0, 1, 32'd5, 1);
      step(1, 32'd773, 0, 0, 0);
      step(1, 32'd517, 0, 0, 0);
      step(1, 32'd1029, 0, 0, 0);

      // R7: interleaved aliasing stream, all tables train each time
      phase = "R7";
      for (int r = 0; r < 2; r++) begin
         step(1, 32'd128, 1, 32'd128, 1);
         step(1, 32'd640, 1, 32'd640, 0);
         step(1, 32'd1152, 1, 32'd1152, 0);
         step(1, 32'd128, 1, 32'd128, 1);
         step(1, 32'd640, 1, 32'd640, 1);
         step(1, 32'd1152, 1, 32'd1152, 0);
      end

      // R9: same-edge lookup sees old state, later lookup sees new
      phase = "R9";
      step(1, 32'd900, 1, 32'd900, 1);
      step(1, 32'd900, 1, 32'd900, 1);
      step(1, 32'd900, 0, 0, 0);

      // R10: update data without valid leaves counters alone
      phase = "R10";
      for (int k = 0; k < 4; k++) step(0, 0, 0, 32'd300, 1);
      step(1, 32'd300, 0, 0, 0);

      // Random mix with collisions
      phase = "R4 random";
      for (int n = 0; n < 4000; n++) begin
         logic [31:0] lp, upc;
         bit lv, uv, ud;
         lv = ($urandom_range(0, 9) < 8);
         uv = ($urandom_range(0, 9) < 7);
         ud = $urandom_range(0, 1) == 1;
         lp = ($urandom_range(0, 9) == 0) ? $urandom : 32'($urandom_range(0, 2303));
         upc = ($urandom_range(0, 3) == 0) ? lp : 32'($urandom_range(0, 2303));
         step(lv, lp, uv, upc, ud);
      end

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule